// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. Software (or any upstream logic) writes only the data byte into a one-entry holding register. The block adds the low start bit, an optional parity bit and one or two high stop bits by itself. Character length, parity mode and stop count come from static configuration inputs that are sampled when a character is moved into the shift stage.

Bit timing is set by a clock-enable pulse, `baud_tick`, that an external divisor produces at sixteen times the selected bit rate. Standard rates from 300 to 115200 baud therefore need only a different divisor outside this block. The common 8-N-1 and 7-E-1 settings are both reachable through the configuration inputs. When the held character moves into the shift stage, the holding register empties and a one-cycle pulse tells the writer it may supply the next character. A write that arrives while the register is still full is dropped, and a sticky overrun flag records the loss.

Top module: `serial_tx_core`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1, `ready_pulse` is 0 and `overrun` is 0.
- R2: A frame starts with one low start bit. The data bits follow, least significant bit first. Each bit is held for exactly 16 `baud_tick` pulses.
- R3: `cfg_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `wr_data` at or above the selected length are never sent and have no effect on the parity bit.
- R4: `cfg_par` selects the parity bit, which is sent directly after the last data bit. Code 1 is even parity, so the data bits plus the parity bit hold an even count of ones. Code 2 is odd parity. Code 3 (mark) always sends 1 and code 4 (space) always sends 0. Codes 0, 5, 6 and 7 send no parity bit.
- R5: `cfg_two_stop` = 0 sends one high stop bit and `cfg_two_stop` = 1 sends two. When a second character is already held, its start bit begins exactly 16 × (frame bit count) ticks after the previous start bit.
- R6: A write (`wr_en` high) with `hold_empty` high is accepted, so `hold_empty` is 0 in the following cycle. If the line is idle, the start bit appears and `hold_empty` returns to 1 on the next clock edge.
- R7: A write while `hold_empty` is 0 is ignored: the held character is unchanged. `overrun` goes high in the next cycle and stays high until reset.
- R8: `ready_pulse` is high for exactly one cycle each time the held character moves into the shift stage. It is high in the same cycle that `hold_empty` rises.
- R9: When no frame is in progress, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Clock enable at 16 × bit rate |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register can take a character |
| ready_pulse | output | 1 | One-cycle pulse when the held character moves into the shift stage |
| overrun | output | 1 | Sticky flag for a write dropped while full |

## Verification
An accepted write is visible one cycle later as `hold_empty` low. On an idle line, the next edge moves the character into the shift stage: the start bit, `hold_empty` high and `ready_pulse` all appear together two edges after the write. The bench samples these on the falling edges that follow each of those clock edges. Each serial bit changes on the edge that carries its sixteenth tick, so the bench counts ticks from the start-bit edge and samples bit j once tick 16·j+8 has been seen. It measures the distance to the next start bit as a tick count. An overrun is sampled one cycle after the dropped write, and again once both frames have finished.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int MAX_DATA = 8;
  localparam int MIN_DATA = 5;
  localparam int MAX_STOP = 2;
  localparam int FRAME_W  = 1 + MAX_DATA + 1 + MAX_STOP;
  localparam int NBITS_W  = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_e;

  function automatic int data_bits(logic [1:0] len_code);
    return MIN_DATA + int'(len_code);
  endfunction

  function automatic logic [MAX_DATA-1:0] keep_low(logic [MAX_DATA-1:0] d, logic [1:0] len_code);
    logic [MAX_DATA-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < data_bits(len_code)) m[i] = d[i];
    return m;
  endfunction

  function automatic logic parity_on(logic [2:0] mode);
    return (mode >= PAR_EVEN) && (mode <= PAR_SPACE);
  endfunction

  function automatic logic parity_bit(logic [2:0] mode, logic [MAX_DATA-1:0] masked);
    case (mode)
      PAR_EVEN:  return ^masked;
      PAR_ODD:   return ~(^masked);
      PAR_MARK:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [NBITS_W-1:0] frame_len(logic [1:0] len_code, logic [2:0] mode, logic two_stop);
    int n;
    n = 1 + data_bits(len_code) + (parity_on(mode) ? 1 : 0) + (two_stop ? 2 : 1);
    return NBITS_W'(n);
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(logic [MAX_DATA-1:0] d, logic [1:0] len_code,
                                                      logic [2:0] mode);
    logic [FRAME_W-1:0] f;
    int nd;
    f  = '1;
    nd = data_bits(len_code);
    f[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < nd) f[1+i] = d[i];
    if (parity_on(mode)) f[1+nd] = parity_bit(mode, keep_low(d, len_code));
    return f;
  endfunction
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          overrun,
  output logic          ready
);
  logic accept, reject;
  assign accept = wr_en & ~full;
  assign reject = wr_en & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      data    <= '0;
      overrun <= 1'b0;
      ready   <= 1'b0;
    end else begin
      ready <= take;
      if (accept) begin
        full <= 1'b1;
        data <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
      if (reject) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_frame_pack.sv
module tx_frame_pack
  import sertx_pkg::*;
(
  input  logic [MAX_DATA-1:0] data,
  input  logic [1:0]          len_code,
  input  logic [2:0]          par_code,
  input  logic                two_stop,
  output logic [FRAME_W-1:0]  frame,
  output logic [NBITS_W-1:0]  nbits
);
  always_comb begin
    frame = build_frame(data, len_code, par_code);
    nbits = frame_len(len_code, par_code, two_stop);
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int TICKS = 16,
  parameter int FW    = 12,
  parameter int NW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic [NW-1:0] nbits,
  output logic          txd,
  output logic          busy
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [CW-1:0] sub;
  logic [FW-1:0] sh;
  logic [NW-1:0] left;
  logic          bit_done;

  assign busy     = (left != '0);
  assign bit_done = tick && (sub == CW'(TICKS - 1));
  assign txd      = sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      sub  <= '0;
    end else if (load) begin
      sh   <= frame;
      left <= nbits;
      sub  <= '0;
    end else if (busy && tick) begin
      if (bit_done) begin
        sub  <= '0;
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_tick,
  input  logic [1:0]          cfg_len,
  input  logic [2:0]          cfg_par,
  input  logic                cfg_two_stop,
  input  logic                wr_en,
  input  logic [MAX_DATA-1:0] wr_data,
  output logic                txd,
  output logic                hold_empty,
  output logic                ready_pulse,
  output logic                overrun
);
  logic                hold_full;
  logic [MAX_DATA-1:0] hold_data;
  logic                line_busy;
  logic                xfer;
  logic [FRAME_W-1:0]  frame;
  logic [NBITS_W-1:0]  nbits;

  assign xfer       = hold_full & ~line_busy;
  assign hold_empty = ~hold_full;

  tx_hold_reg #(.DW(MAX_DATA)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (xfer),
    .full    (hold_full),
    .data    (hold_data),
    .overrun (overrun),
    .ready   (ready_pulse)
  );

  tx_frame_pack u_pack (
    .data     (hold_data),
    .len_code (cfg_len),
    .par_code (cfg_par),
    .two_stop (cfg_two_stop),
    .frame    (frame),
    .nbits    (nbits)
  );

  tx_shifter #(.TICKS(TICKS_PER_BIT), .FW(FRAME_W), .NW(NBITS_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (baud_tick),
    .load  (xfer),
    .frame (frame),
    .nbits (nbits),
    .txd   (txd),
    .busy  (line_busy)
  );
endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic txd,
  input logic hold_empty,
  input logic ready_pulse,
  input logic overrun,
  input logic line_busy
);
  // R6
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold_empty) |=> !hold_empty);
  // R7
  drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hold_empty) |=> overrun);
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R8
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse |=> !ready_pulse);
  // R8
  ready_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse |-> hold_empty);
  // R8
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> ready_pulse);
  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_busy |-> txd);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_busy) |-> !txd);
endmodule

bind serial_tx_core serial_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .txd         (txd),
  .hold_empty  (hold_empty),
  .ready_pulse (ready_pulse),
  .overrun     (overrun),
  .line_busy   (line_busy)
);

// File: tb/sim_serial_tx_core.sv
module sim_serial_tx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_par = 3'd0;
  logic       cfg_two_stop = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, hold_empty, ready_pulse, overrun;
  int         n_chk = 0;
  int         n_fail = 0;
  int         tick_ph = 0;

  serial_tx_core u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .wr_en(wr_en),
    .wr_data(wr_data), .txd(txd), .hold_empty(hold_empty),
    .ready_pulse(ready_pulse), .overrun(overrun)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    baud_tick = (tick_ph == 2);
    tick_ph   = (tick_ph == 2) ? 0 : tick_ph + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_nbits(logic [1:0] len, logic [2:0] par, logic two);
    return 1 + 5 + int'(len) + ((par >= 3'd1 && par <= 3'd4) ? 1 : 0) + (two ? 2 : 1);
  endfunction

  function automatic logic [11:0] exp_frame(logic [7:0] d, logic [1:0] len, logic [2:0] par, logic two);
    logic [11:0] v;
    int nd, ones, nb;
    v = '0; nd = 5 + int'(len); ones = 0; nb = exp_nbits(len, par, two);
    for (int j = 0; j < nd; j++) ones += int'(d[j]);
    for (int j = 0; j < nb; j++) begin
      if (j == 0) v[j] = 1'b0;
      else if (j <= nd) v[j] = d[j-1];
      else if (j == nd + 1 && par >= 3'd1 && par <= 3'd4)
        v[j] = (par == 3'd1) ? ones[0] : (par == 3'd2) ? ~ones[0] : (par == 3'd3);
      else v[j] = 1'b1;
    end
    return v;
  endfunction

  task automatic wait_start();
    do begin @(posedge clk); #1; end while (txd != 1'b0);
  endtask

  task automatic rx_frame(input int nb, output logic [11:0] got, output int k_fall);
    int  k;
    bit  t;
    logic prev;
    k = 0; got = '0; prev = 1'b0; k_fall = -1;
    while (1) begin
      @(posedge clk); t = baud_tick; #1;
      if (t) k++;
      if (t && (k % 16 == 8) && (k / 16 < nb)) got[k/16] = txd;
      if (k >= 16 * nb && prev && !txd) begin k_fall = k; break; end
      if (k >= 16 * nb + 48) break;
      prev = txd;
    end
  endtask

  task automatic run_pair(input logic [7:0] d0, input logic [7:0] d1, input logic [1:0] len,
                          input logic [2:0] par, input logic two, input bit drop);
    logic [11:0] g0, g1;
    int k0, k1, nb;
    @(negedge clk);
    cfg_len = len; cfg_par = par; cfg_two_stop = two;
    nb = exp_nbits(len, par, two);
    fork
      begin
        @(negedge clk); wr_en = 1'b1; wr_data = d0;
        @(negedge clk); wr_en = 1'b0;
        chk(hold_empty == 1'b0, "R6 full after write", int'(hold_empty), 0);
        @(negedge clk);
        chk(hold_empty && ready_pulse && !txd, "R6/R8 transfer one edge later",
            int'({hold_empty, ready_pulse, txd}), 6);
        wr_en = 1'b1; wr_data = d1;
        @(negedge clk); wr_en = 1'b0;
        chk(!ready_pulse && !hold_empty, "R8 pulse one cycle", int'({ready_pulse, hold_empty}), 0);
        if (drop) begin
          wr_en = 1'b1; wr_data = ~d1;
          @(negedge clk); wr_en = 1'b0;
          chk(overrun == 1'b1, "R7 overrun set", int'(overrun), 1);
        end
      end
      begin
        wait_start();
        rx_frame(nb, g0, k0);
        rx_frame(nb, g1, k1);
      end
    join
    // R2 R3 R4 frame content
    chk(g0 == exp_frame(d0, len, par, two), "R2/R3/R4 first frame", int'(g0), int'(exp_frame(d0, len, par, two)));
    // R7 held byte unchanged by dropped write
    chk(g1 == exp_frame(d1, len, par, two), "R7/R3 second frame", int'(g1), int'(exp_frame(d1, len, par, two)));
    chk(k0 == 16 * nb, "R5 frame length in ticks", k0, 16 * nb);
    chk(k1 == -1 && txd == 1'b1 && hold_empty, "R9 idle high", k1, -1);
    if (drop) chk(overrun == 1'b1, "R7 overrun stays", int'(overrun), 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(hold_empty == 1'b1, "R1 hold_empty", int'(hold_empty), 1);
    chk(ready_pulse == 1'b0, "R1 ready_pulse", int'(ready_pulse), 0);
    chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
    run_pair(8'hA5, 8'h3C, 2'd3, 3'd0, 1'b0, 1'b0);   // 8-N-1
    run_pair(8'h9C, 8'hFF, 2'd2, 3'd1, 1'b0, 1'b0);   // 7-E-1, bit 7 set (R3)
    run_pair(8'hE7, 8'h18, 2'd0, 3'd3, 1'b1, 1'b0);   // R3 5 bits, R4 mark, R5 two stop
    run_pair(8'hC1, 8'h00, 2'd1, 3'd4, 1'b0, 1'b0);   // R4 space
    run_pair(8'h80, 8'h7F, 2'd3, 3'd2, 1'b1, 1'b0);   // R4 odd
    run_pair(8'h55, 8'hAA, 2'd2, 3'd6, 1'b0, 1'b0);   // R4 reserved code
    for (int i = 0; i < 30; i++)
      run_pair(8'($urandom), 8'($urandom), 2'($urandom), 3'($urandom), 1'($urandom), 1'b0);
    chk(overrun == 1'b0, "R7 no overrun without drop", int'(overrun), 0);
    run_pair(8'h6B, 8'h92, 2'd3, 3'd1, 1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(overrun == 1'b0 && txd && hold_empty, "R1 reset clears overrun", int'(overrun), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule